// File: doc/BRIEF.md
# Page-One Stack Pointer Sequencer

This block keeps the 8-bit stack pointer of a small 8-bit processor and issues the sequence of stack memory addresses needed by every stack-using operation. Each address has a fixed upper byte (page one), so the stack always occupies 0x0100 to 0x01FF. The pointer moves down as bytes are written and up as bytes are read, and it wraps within the page.

The caller issues a single-cycle one-hot strobe on `cmd_i`. Single-byte stores and loads cover the accumulator and the status byte. A call stores two return-address bytes. A return loads them back. An interrupt entry stores three bytes. A transfer command loads the pointer from an 8-bit value, and an initialise command sets it to its reset value. During each memory access cycle the block drives `mem_valid_o`, `mem_we_o`, `mem_addr_o` and a slot tag that says which byte of the sequence is being moved. Memory, decode and interrupt control are outside the block.

The sequencer has eight named states. ST_IDLE accepts commands. ST_PUSH_ONE and ST_PULL_ONE are single-byte accesses. ST_PUSH_PCH, ST_PUSH_PCL and ST_PUSH_STS store the program counter high byte, the low byte and the status byte. ST_PULL_PCL and ST_PULL_PCH load the return address. The transitions are:
- ST_IDLE to ST_PUSH_ONE, ST_PULL_ONE, ST_PUSH_PCH (call or interrupt) or ST_PULL_PCL (return).
- ST_PUSH_PCH to ST_PUSH_PCL.
- ST_PUSH_PCL to ST_PUSH_STS for an interrupt, or to ST_IDLE for a call.
- ST_PULL_PCL to ST_PULL_PCH.
- ST_PUSH_ONE, ST_PULL_ONE, ST_PUSH_STS and ST_PULL_PCH return to ST_IDLE.

Top module: `pg1_stack_unit`

## Requirements
- R1: After reset the pointer reads 0xFD, `busy_o` is 0 and `mem_valid_o` is 0.
- R2: A single store (`cmd_i` bit 0) issues one access on the following cycle. In that access `mem_we_o`=1, the address is 0x0100 plus the current pointer, and the slot is 0. The pointer then decrements.
- R3: A single load (`cmd_i` bit 1) first increments the pointer. It then issues one access with `mem_we_o`=0 and slot 0 at 0x0100 plus the new pointer.
- R4: The pointer wraps modulo 256 in both directions, and the upper address byte of every access is 0x01.
- R5: A call (`cmd_i` bit 2) issues two write accesses on consecutive cycles. The first is slot 1 (PC high). The second is slot 2 (PC low). The pointer drops by 2.
- R6: A return (`cmd_i` bit 3) issues two read accesses on consecutive cycles. The first is slot 2 (PC low). The second is slot 1 (PC high). The pointer rises by 2.
- R7: An interrupt entry (`cmd_i` bit 4) issues three write accesses on consecutive cycles, in the order slot 1, slot 2, slot 3 (status). The pointer drops by 3.
- R8: A transfer (`cmd_i` bit 5) loads the pointer from `load_val_i` at the next edge. It causes no memory access.
- R9: An initialise (`cmd_i` bit 6) sets the pointer to 0xFD at the next edge. It causes no memory access.
- R10: `busy_o` is 1 while a sequence is in progress. Any strobe that arrives during that time is ignored, so it changes neither the pointer nor the access stream.
- R11: In ST_IDLE, a `cmd_i` value with more than one bit set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 7 | One-hot command strobe: bit 0 store, 1 load, 2 call, 3 return, 4 interrupt, 5 transfer, 6 initialise |
| load_val_i | input | 8 | Value for the transfer command |
| busy_o | output | 1 | A multi-cycle sequence is in progress |
| mem_valid_o | output | 1 | Stack memory access this cycle |
| mem_we_o | output | 1 | 1 = write (push), 0 = read (pull) |
| mem_addr_o | output | 16 | Stack byte address |
| slot_o | output | 2 | Byte tag: 0 single, 1 PC high, 2 PC low, 3 status |
| sp_o | output | 8 | Current stack pointer |

## Verification
A new command strobe and an access cycle of a sequence already under way can fall in the same cycle. The clash that matters most is a transfer or initialise strobe arriving during the second or third byte of a call or interrupt entry. Random strobes are therefore fired on every cycle, including cycles where `busy_o` is high, and directed cases place a transfer strobe in the middle of an interrupt entry. A reference model in the bench drops every strobe it sees while a sequence is pending. The pointer, address and slot stream of the design are compared with that model on every cycle.

// File: rtl/pg1_stack_pkg.sv
package pg1_stack_pkg;

    localparam int CMD_W    = 7;
    localparam int CMD_PUSH = 0;
    localparam int CMD_PULL = 1;
    localparam int CMD_CALL = 2;
    localparam int CMD_RET  = 3;
    localparam int CMD_IRQ  = 4;
    localparam int CMD_LOAD = 5;
    localparam int CMD_INIT = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_ONE,
        ST_PULL_ONE,
        ST_PUSH_PCH,
        ST_PUSH_PCL,
        ST_PUSH_STS,
        ST_PULL_PCL,
        ST_PULL_PCH
    } stk_state_e;

    typedef enum logic [1:0] {
        SL_SINGLE = 2'd0,
        SL_PC_HI  = 2'd1,
        SL_PC_LO  = 2'd2,
        SL_STATUS = 2'd3
    } slot_e;

endpackage

// File: rtl/stk_seq_fsm.sv
module stk_seq_fsm
    import pg1_stack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] cmd_i,
    output logic             busy_o,
    output logic             acc_valid_o,
    output logic             acc_we_o,
    output slot_e            slot_o,
    output logic             sp_dec_o,
    output logic             sp_inc_o,
    output logic             sp_ld_o,
    output logic             sp_init_o
);

    localparam logic [CMD_W-1:0] CMD_ONE = {{(CMD_W-1){1'b0}}, 1'b1};

    stk_state_e state_q, state_d;
    logic       irq_q, irq_d;
    logic       cmd_legal;

    // exactly one strobe bit set
    assign cmd_legal = (cmd_i != '0) && ((cmd_i & (cmd_i - CMD_ONE)) == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_d;
        end
    end

    always_comb begin
        state_d = state_q;
        irq_d   = irq_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_legal) begin
                    if (cmd_i[CMD_PUSH]) begin
                        state_d = ST_PUSH_ONE;
                    end else if (cmd_i[CMD_PULL]) begin
                        state_d = ST_PULL_ONE;
                    end else if (cmd_i[CMD_CALL]) begin
                        state_d = ST_PUSH_PCH;
                        irq_d   = 1'b0;
                    end else if (cmd_i[CMD_IRQ]) begin
                        state_d = ST_PUSH_PCH;
                        irq_d   = 1'b1;
                    end else if (cmd_i[CMD_RET]) begin
                        state_d = ST_PULL_PCL;
                    end
                end
            end
            ST_PUSH_ONE: state_d = ST_IDLE;
            ST_PULL_ONE: state_d = ST_IDLE;
            ST_PUSH_PCH: state_d = ST_PUSH_PCL;
            ST_PUSH_PCL: state_d = irq_q ? ST_PUSH_STS : ST_IDLE;
            ST_PUSH_STS: state_d = ST_IDLE;
            ST_PULL_PCL: state_d = ST_PULL_PCH;
            ST_PULL_PCH: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o      = 1'b1;
        acc_valid_o = 1'b0;
        acc_we_o    = 1'b0;
        slot_o      = SL_SINGLE;
        sp_dec_o    = 1'b0;
        sp_inc_o    = 1'b0;
        sp_ld_o     = 1'b0;
        sp_init_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o    = 1'b0;
                sp_ld_o   = cmd_legal & cmd_i[CMD_LOAD];
                sp_init_o = cmd_legal & cmd_i[CMD_INIT];
            end
            ST_PUSH_ONE: begin
                acc_valid_o = 1'b1;
                acc_we_o    = 1'b1;
                sp_dec_o    = 1'b1;
            end
            ST_PULL_ONE: begin
                acc_valid_o = 1'b1;
                sp_inc_o    = 1'b1;
            end
            ST_PUSH_PCH: begin
                acc_valid_o = 1'b1;
                acc_we_o    = 1'b1;
                sp_dec_o    = 1'b1;
                slot_o      = SL_PC_HI;
            end
            ST_PUSH_PCL: begin
                acc_valid_o = 1'b1;
                acc_we_o    = 1'b1;
                sp_dec_o    = 1'b1;
                slot_o      = SL_PC_LO;
            end
            ST_PUSH_STS: begin
                acc_valid_o = 1'b1;
                acc_we_o    = 1'b1;
                sp_dec_o    = 1'b1;
                slot_o      = SL_STATUS;
            end
            ST_PULL_PCL: begin
                acc_valid_o = 1'b1;
                sp_inc_o    = 1'b1;
                slot_o      = SL_PC_LO;
            end
            ST_PULL_PCH: begin
                acc_valid_o = 1'b1;
                sp_inc_o    = 1'b1;
                slot_o      = SL_PC_HI;
            end
            default: busy_o = 1'b1;
        endcase
    end

    // R5
    call_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PUSH_PCH |=> state_q == ST_PUSH_PCL);

    // R6
    ret_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PULL_PCL |=> state_q == ST_PULL_PCH);

    // R7
    irq_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH_PCL && irq_q) |=> state_q == ST_PUSH_STS);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !(sp_ld_o || sp_init_o));

    // R11
    multi_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $countones(cmd_i) > 1) |=> state_q == ST_IDLE);

endmodule

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
    parameter int           W         = 8,
    parameter logic [W-1:0] RESET_VAL = 8'hFD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dec_i,
    input  logic         inc_i,
    input  logic         ld_i,
    input  logic         init_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] sp_o,
    output logic [W-1:0] sp_next_up_o
);

    localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= RESET_VAL;
        end else if (ld_i) begin
            sp_q <= ld_val_i;
        end else if (init_i) begin
            sp_q <= RESET_VAL;
        end else if (inc_i) begin
            sp_q <= sp_q + STEP;
        end else if (dec_i) begin
            sp_q <= sp_q - STEP;
        end
    end

    assign sp_o         = sp_q;
    assign sp_next_up_o = sp_q + STEP;

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |=> sp_q == $past(sp_q) - STEP);

    // R3
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> sp_q == $past(sp_q) + STEP);

    // R8
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> sp_q == $past(ld_val_i));

    // R9
    init_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> sp_q == RESET_VAL);

    // R10
    one_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dec_i, inc_i, ld_i, init_i}) <= 1);

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
    parameter int           W       = 8,
    parameter logic [W-1:0] PAGE_ID = 8'h01
) (
    input  logic           we_i,
    input  logic [W-1:0]   sp_i,
    input  logic [W-1:0]   sp_up_i,
    output logic [2*W-1:0] addr_o
);

    logic [W-1:0] low_byte;

    // a write uses the pointer as it stands, a read the pre-incremented one
    assign low_byte = we_i ? sp_i : sp_up_i;
    assign addr_o   = {PAGE_ID, low_byte};

endmodule

// File: rtl/pg1_stack_unit.sv
module pg1_stack_unit
    import pg1_stack_pkg::*;
#(
    parameter int              SP_W     = 8,
    parameter logic [SP_W-1:0] PAGE_ID  = 8'h01,
    parameter logic [SP_W-1:0] RESET_SP = 8'hFD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [SP_W-1:0]   load_val_i,
    output logic              busy_o,
    output logic              mem_valid_o,
    output logic              mem_we_o,
    output logic [2*SP_W-1:0] mem_addr_o,
    output logic [1:0]        slot_o,
    output logic [SP_W-1:0]   sp_o
);

    localparam int              AW   = 2 * SP_W;
    localparam logic [SP_W-1:0] STEP = {{(SP_W-1){1'b0}}, 1'b1};

    slot_e            slot_w;
    logic             dec_w, inc_w, ld_w, init_w;
    logic [SP_W-1:0]  sp_w, sp_up_w;

    stk_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd_i),
        .busy_o      (busy_o),
        .acc_valid_o (mem_valid_o),
        .acc_we_o    (mem_we_o),
        .slot_o      (slot_w),
        .sp_dec_o    (dec_w),
        .sp_inc_o    (inc_w),
        .sp_ld_o     (ld_w),
        .sp_init_o   (init_w)
    );

    stk_ptr_reg #(
        .W         (SP_W),
        .RESET_VAL (RESET_SP)
    ) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .dec_i        (dec_w),
        .inc_i        (inc_w),
        .ld_i         (ld_w),
        .init_i       (init_w),
        .ld_val_i     (load_val_i),
        .sp_o         (sp_w),
        .sp_next_up_o (sp_up_w)
    );

    stk_addr_gen #(
        .W       (SP_W),
        .PAGE_ID (PAGE_ID)
    ) u_addr (
        .we_i    (mem_we_o),
        .sp_i    (sp_w),
        .sp_up_i (sp_up_w),
        .addr_o  (mem_addr_o)
    );

    assign slot_o = slot_w;
    assign sp_o   = sp_w;

    // R2
    push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_we_o) |=> sp_o == $past(mem_addr_o[SP_W-1:0]) - STEP);

    // R3
    pull_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_we_o) |=> sp_o == $past(mem_addr_o[SP_W-1:0]));

    // R4
    page_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> mem_addr_o[AW-1:SP_W] == PAGE_ID);

endmodule

// File: tb/pg1_stack_unit_tb.sv
module pg1_stack_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cmd_i = '0;
    logic [7:0]  load_val_i = '0;
    logic        busy_o, mem_valid_o, mem_we_o;
    logic [15:0] mem_addr_o;
    logic [1:0]  slot_o;
    logic [7:0]  sp_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // reference model
    logic [7:0] m_sp;
    int         p_n;
    int         p_i;
    logic       p_we   [3];
    logic [1:0] p_slot [3];
    string      p_tag  [3];
    string      sp_tag;

    always #10 clk = ~clk;

    pg1_stack_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd_i),
        .load_val_i  (load_val_i),
        .busy_o      (busy_o),
        .mem_valid_o (mem_valid_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .slot_o      (slot_o),
        .sp_o        (sp_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic bit is_onehot(input logic [6:0] c);
        return (c != 0) && ((c & (c - 7'd1)) == 0);
    endfunction

    function automatic logic [15:0] exp_addr(input logic we, input logic [7:0] sp);
        return {8'h01, we ? sp : sp + 8'd1};
    endfunction

    task automatic queue3(input logic w, input logic [1:0] s0, input logic [1:0] s1,
                          input logic [1:0] s2, input int n, input string tag);
        p_n = n; p_i = 0;
        p_we[0] = w; p_we[1] = w; p_we[2] = w;
        p_slot[0] = s0; p_slot[1] = s1; p_slot[2] = s2;
        p_tag[0] = tag; p_tag[1] = tag; p_tag[2] = tag;
    endtask

    // compare outputs of this cycle, then apply stimulus and advance the model
    task automatic step(input logic [6:0] c, input logic [7:0] v);
        @(negedge clk);
        cyc++;
        chk("R10 busy", busy_o, p_i < p_n);
        chk({sp_tag, " pointer"}, sp_o, m_sp);
        chk("R10 valid", mem_valid_o, p_i < p_n);
        if (p_i < p_n) begin
            chk({p_tag[p_i], " write"}, mem_we_o, p_we[p_i]);
            chk({p_tag[p_i], " address"}, mem_addr_o, exp_addr(p_we[p_i], m_sp));
            chk("R4 page", mem_addr_o[15:8], 8'h01);
            chk({p_tag[p_i], " slot"}, slot_o, p_slot[p_i]);
        end
        cmd_i = c;
        load_val_i = v;
        if (p_i < p_n) begin
            if (p_we[p_i]) m_sp = m_sp - 8'd1;
            else           m_sp = m_sp + 8'd1;
            sp_tag = (c != 0) ? "R10" : p_tag[p_i];
            p_i++;
        end else if (c == 0) begin
            sp_tag = "R1";
        end else if (!is_onehot(c)) begin
            sp_tag = "R11";
        end else if (c[0]) queue3(1'b1, 2'd0, 2'd0, 2'd0, 1, "R2");
        else if (c[1])     queue3(1'b0, 2'd0, 2'd0, 2'd0, 1, "R3");
        else if (c[2])     queue3(1'b1, 2'd1, 2'd2, 2'd0, 2, "R5");
        else if (c[3])     queue3(1'b0, 2'd2, 2'd1, 2'd0, 2, "R6");
        else if (c[4])     queue3(1'b1, 2'd1, 2'd2, 2'd3, 3, "R7");
        else if (c[5]) begin m_sp = v;     sp_tag = "R8"; end
        else begin           m_sp = 8'hFD; sp_tag = "R9"; end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(7'd0, 8'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int w = 0; w < 200000; w++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        m_sp = 8'hFD; p_n = 0; p_i = 0; sp_tag = "R1";
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk("R1 reset pointer", sp_o, 8'hFD);
        chk("R1 reset busy", busy_o, 1'b0);
        chk("R1 reset valid", mem_valid_o, 1'b0);
        // R2 single push, R3 single pull
        step(7'h01, 8'd0); idle(2);
        step(7'h02, 8'd0); idle(2);
        // R4 wrap downward: load 0x00 then push
        step(7'h20, 8'h00); step(7'h01, 8'd0); idle(2);
        chk("R4 wrap down", sp_o, 8'hFF);
        // R4 wrap upward: pull from 0xFF reads 0x0100
        step(7'h02, 8'd0); idle(2);
        chk("R4 wrap up", sp_o, 8'h00);
        // R9 initialise
        step(7'h40, 8'd0); idle(1);
        // R5 call then R6 return
        step(7'h04, 8'd0); idle(3);
        step(7'h08, 8'd0); idle(3);
        // R7 interrupt with R10 transfer and initialise strobes mid-sequence
        step(7'h10, 8'd0); step(7'h20, 8'h55); step(7'h40, 8'd0); step(7'h01, 8'd0);
        idle(2);
        chk("R10 no load during busy", sp_o, 8'hFA);
        // R11 multi-bit strobes
        step(7'h21, 8'h33); step(7'h06, 8'd0); step(7'h7F, 8'h10); idle(2);
        chk("R11 ignored", sp_o, 8'hFA);
        // R8 transfer
        step(7'h20, 8'h80); idle(1);
        chk("R8 transfer", sp_o, 8'h80);
        // random mix
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [6:0] c;
            r = $urandom_range(0, 99);
            if (r < 40)      c = 7'd0;
            else if (r < 90) c = 7'd1 << $urandom_range(0, 6);
            else             c = 7'($urandom_range(0, 127));
            step(c, 8'($urandom_range(0, 255)));
        end
        idle(4);
        finish_run();
    end

endmodule